// File: doc/BRIEF.md
# Page Clear and Unprotected-Field Erase Scanner

This sequencer walks a character page held in an external memory, one cell at a time, left to right along a line and then down to the next line. For every cell it issues a read, inspects the returned character, and then writes the same address. The written value is either the character itself or the null code, depending on the operation that was started.

Two operations exist. A page clear writes null to every cell. An unprotected-field erase keeps field attribute codes and the cells those codes mark as protected, and keeps ruling characters unless a strap allows erasing them. Every other cell is overwritten with null. The scanner raises a memory-access flag for the length of the scan and gives a one-clock completion pulse when it ends.

Characters are 10 bits wide. Bit 8 set marks a field attribute code. In an attribute code, bit 2 set means the cells after it are protected. Bit 9 set marks a ruling character.

Top module: `page_scrub`

## Requirements
- R1: A start request while idle makes `dmaActive` high from the next clock. The first cycle of the scan is a read of column 0, row 0.
- R2: Each cell takes two cycles: a read cycle (`memRdEn`=1) and then a write cycle (`memWrEn`=1) to the same column and row. The two enables are never high together.
- R3: Cells are visited in row-major order. The column runs from 0 to COLS-1, and after column COLS-1 the column returns to 0 and the row advances.
- R4: After the write of the last cell (column COLS-1, row ROWS-1), `scanDone` is high for exactly one clock, `dmaActive` is low in that same clock, and column and row are back at 0. The scan takes 2·COLS·ROWS cycles.
- R5: In page-clear mode (`eraseMode`=0), every write carries the value 0x000.
- R6: In erase mode (`eraseMode`=1), a character with bit 8 set is written back with its exact 10-bit value.
- R7: In erase mode, bit 2 of the latest attribute code on the line decides the cells that follow it. When bit 2 is 1 those cells are written back unchanged; when it is 0 they are written as 0x000. This holds until the next attribute code or the end of the line.
- R8: At the start of every line the protection state is unprotected. Protection never carries from one line into the next.
- R9: In erase mode, a character with bit 9 set is written back unchanged when `rulingErasable`=0. When `rulingErasable`=1 it is treated like any other data cell.
- R10: A start request while `dmaActive` is high is ignored. The scan order and duration are unchanged.
- R11: `eraseMode` and `rulingErasable` are sampled only when a start is accepted. Changing them during a scan has no effect on the written data.
- R12: After reset, `dmaActive`, `scanDone`, `memRdEn` and `memWrEn` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start a scan (accepted only when idle) |
| eraseMode | input | 1 | 0 = page clear, 1 = unprotected-field erase |
| rulingErasable | input | 1 | 1 = ruling characters may be erased |
| memRdEn | output | 1 | Memory read strobe; data returns the next cycle |
| memWrEn | output | 1 | Memory write strobe |
| memCol | output | $clog2(COLS) | Column address |
| memRow | output | $clog2(ROWS) | Row address |
| memRdData | input | 10 | Character read from memory (valid the cycle after the read) |
| memWrData | output | 10 | Character to write |
| dmaActive | output | 1 | High while a scan owns the memory |
| scanDone | output | 1 | One-clock pulse at the end of a scan |

## Verification
The hardest case to reach from the ports is protection that must stop at a line boundary. A protecting attribute code in the last column, or a protected run that reaches the end of a line, must not leave the next line protected. Random pages seldom place an attribute code there, so a directed page puts protecting attribute codes at the end of a line and plain data at the start of the next one. A second hard case is a start request or a mode change that arrives in the middle of a scan. The bench raises these at arbitrary points during a running erase and compares the whole page against a model that uses the settings captured at the start.

// File: rtl/page_scrub_pkg.sv
`timescale 1ns/1ps
package page_scrub_pkg;
  localparam int CHAR_W   = 10;
  localparam int ATTR_BIT = 8;
  localparam int RULE_BIT = 9;
  localparam int PROT_BIT = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } scanState_t;

  typedef struct packed {
    logic cfgLoad;    // start accepted: capture mode and strap
    logic cellWrite;  // write cycle of a cell
    logic lineStart;  // write cycle at column 0
    logic lineEnd;    // write cycle at last column
  } scanStb_t;
endpackage

// File: rtl/page_scrub_ctrl.sv
`timescale 1ns/1ps
module page_scrub_ctrl
  import page_scrub_pkg::*;
#(
  parameter int COLS = 80,
  parameter int ROWS = 24,
  localparam int COL_W = $clog2(COLS),
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  output scanStb_t         stb,
  output logic             rdEn,
  output logic             wrEn,
  output logic [COL_W-1:0] colQ,
  output logic [ROW_W-1:0] rowQ,
  output logic             busy,
  output logic             doneQ
);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

  scanState_t state;
  logic       atLastCol;
  logic       atLastRow;

  assign atLastCol = (colQ == LAST_COL);
  assign atLastRow = (rowQ == LAST_ROW);
  assign rdEn      = (state == ST_READ);
  assign wrEn      = (state == ST_WRITE);
  assign busy      = (state != ST_IDLE);

  always_comb begin
    stb           = '0;
    stb.cfgLoad   = (state == ST_IDLE) && startReq;
    stb.cellWrite = wrEn;
    stb.lineStart = wrEn && (colQ == '0);
    stb.lineEnd   = wrEn && atLastCol;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      colQ  <= '0;
      rowQ  <= '0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (startReq) begin
            state <= ST_READ;
            colQ  <= '0;
            rowQ  <= '0;
          end
        end
        ST_READ: state <= ST_WRITE;
        ST_WRITE: begin
          if (atLastCol) begin
            colQ <= '0;
            if (atLastRow) begin
              rowQ  <= '0;
              state <= ST_IDLE;
              doneQ <= 1'b1;
            end else begin
              rowQ  <= rowQ + 1'b1;
              state <= ST_READ;
            end
          end else begin
            colQ  <= colQ + 1'b1;
            state <= ST_READ;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(rdEn && wrEn));
  a_r2_write_after_read: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> (wrEn && $stable(colQ) && $stable(rowQ)));
  a_r3_col_range: assert property (@(posedge clk) disable iff (!rstN)
    colQ <= LAST_COL);
  a_r3_row_step: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && atLastCol && !atLastRow) |=> (colQ == '0 && rowQ == $past(rowQ) + 1'b1));
  a_r4_done_one_clock: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);
  a_r4_done_ends_busy: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> (!busy && colQ == '0 && rowQ == '0));
  a_r10_busy_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && startReq) |=> wrEn);
endmodule

// File: rtl/page_scrub_dp.sv
`timescale 1ns/1ps
module page_scrub_dp
  import page_scrub_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  scanStb_t          stb,
  input  logic              eraseMode,
  input  logic              rulingErasable,
  input  logic [CHAR_W-1:0] rdData,
  output logic [CHAR_W-1:0] wrData
);
  logic modeQ;
  logic strapQ;
  logic protQ;
  logic isAttr;
  logic isRuling;
  logic keepCell;

  assign isAttr   = rdData[ATTR_BIT];
  assign isRuling = rdData[RULE_BIT];

  always_comb begin
    if (!modeQ)
      keepCell = 1'b0;
    else
      keepCell = isAttr || protQ || (isRuling && !strapQ);
  end

  assign wrData = keepCell ? rdData : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ  <= 1'b0;
      strapQ <= 1'b0;
      protQ  <= 1'b0;
    end else begin
      if (stb.cfgLoad) begin
        modeQ  <= eraseMode;
        strapQ <= rulingErasable;
        protQ  <= 1'b0;
      end else if (stb.lineEnd) begin
        protQ <= 1'b0;
      end else if (stb.cellWrite && modeQ && isAttr) begin
        protQ <= rdData[PROT_BIT];
      end
    end
  end

  a_r5_clear_null: assert property (@(posedge clk) disable iff (!rstN)
    (stb.cellWrite && !modeQ) |-> (wrData == '0));
  a_r6_attr_kept: assert property (@(posedge clk) disable iff (!rstN)
    (stb.cellWrite && modeQ && isAttr) |-> (wrData == rdData));
  a_r8_line_start_unprot: assert property (@(posedge clk) disable iff (!rstN)
    (stb.lineStart && modeQ && !isAttr && !isRuling) |-> (wrData == '0));
  a_r9_ruling_kept: assert property (@(posedge clk) disable iff (!rstN)
    (stb.cellWrite && modeQ && isRuling && !strapQ) |-> (wrData == rdData));
  a_r11_cfg_hold: assert property (@(posedge clk) disable iff (!rstN)
    (stb.cellWrite && !stb.cfgLoad) |=> ($stable(modeQ) && $stable(strapQ)));
endmodule

// File: rtl/page_scrub.sv
`timescale 1ns/1ps
module page_scrub
  import page_scrub_pkg::*;
#(
  parameter int COLS = 80,
  parameter int ROWS = 24,
  localparam int COL_W = $clog2(COLS),
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              eraseMode,
  input  logic              rulingErasable,
  output logic              memRdEn,
  output logic              memWrEn,
  output logic [COL_W-1:0]  memCol,
  output logic [ROW_W-1:0]  memRow,
  input  logic [CHAR_W-1:0] memRdData,
  output logic [CHAR_W-1:0] memWrData,
  output logic              dmaActive,
  output logic              scanDone
);
  scanStb_t stb;

  page_scrub_ctrl #(.COLS(COLS), .ROWS(ROWS)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .stb      (stb),
    .rdEn     (memRdEn),
    .wrEn     (memWrEn),
    .colQ     (memCol),
    .rowQ     (memRow),
    .busy     (dmaActive),
    .doneQ    (scanDone)
  );

  page_scrub_dp dp_i (
    .clk            (clk),
    .rstN           (rstN),
    .stb            (stb),
    .eraseMode      (eraseMode),
    .rulingErasable (rulingErasable),
    .rdData         (memRdData),
    .wrData         (memWrData)
  );

  a_r1_start_begins_read: assert property (@(posedge clk) disable iff (!rstN)
    (!dmaActive && startReq) |=> (dmaActive && memRdEn && memCol == '0 && memRow == '0));
endmodule

// File: tb/page_scrub_tb_top.sv
`timescale 1ns/1ps
module page_scrub_tb_top;
  localparam int COLS  = 80;
  localparam int ROWS  = 24;
  localparam int CELLS = COLS * ROWS;
  localparam int COL_W = $clog2(COLS);
  localparam int ROW_W = $clog2(ROWS);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic eraseMode = 1'b0;
  logic rulingErasable = 1'b0;
  logic memRdEn, memWrEn, dmaActive, scanDone;
  logic [COL_W-1:0] memCol;
  logic [ROW_W-1:0] memRow;
  logic [9:0] memRdData;
  logic [9:0] memWrData;

  logic [9:0] mem    [CELLS];
  logic [9:0] img    [CELLS];
  logic [9:0] expMem [CELLS];
  logic loadReq = 1'b0;
  logic monClr = 1'b0;
  int   monIdx;
  int   orderErr;
  logic lastRd;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  page_scrub #(.COLS(COLS), .ROWS(ROWS)) dut_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .eraseMode(eraseMode),
    .rulingErasable(rulingErasable), .memRdEn(memRdEn), .memWrEn(memWrEn),
    .memCol(memCol), .memRow(memRow), .memRdData(memRdData),
    .memWrData(memWrData), .dmaActive(dmaActive), .scanDone(scanDone)
  );

  // synchronous memory model: read data appears the cycle after the read
  always_ff @(posedge clk) begin
    if (loadReq) begin
      for (int i = 0; i < CELLS; i++) mem[i] <= img[i];
    end else begin
      if (memWrEn) mem[int'(memRow) * COLS + int'(memCol)] <= memWrData;
    end
    if (memRdEn) memRdData <= mem[int'(memRow) * COLS + int'(memCol)];
  end

  // access-order monitor (R2, R3)
  always_ff @(posedge clk) begin
    if (monClr) begin
      monIdx   <= 0;
      orderErr <= 0;
      lastRd   <= 1'b0;
    end else begin
      lastRd <= memRdEn;
      if (memRdEn && (int'(memRow) * COLS + int'(memCol) != monIdx || memWrEn))
        orderErr <= orderErr + 1;
      if (memWrEn) begin
        if (int'(memRow) * COLS + int'(memCol) != monIdx || !lastRd)
          orderErr <= orderErr + 1;
        monIdx <= monIdx + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] randCell();
    int r = int'($urandom % 16);
    logic [9:0] v = 10'($urandom % 256);
    if (r == 0) v = {1'($urandom % 2), 1'b1, 8'($urandom % 256)};
    else if (r == 1) v = {1'b1, 1'b0, 8'($urandom % 256)};
    return v;
  endfunction

  // reference model from the requirements
  task automatic buildExpected(input bit erase, input bit strap);
    for (int r = 0; r < ROWS; r++) begin
      bit prot = 1'b0;
      for (int c = 0; c < COLS; c++) begin
        logic [9:0] v = img[r * COLS + c];
        if (!erase) expMem[r * COLS + c] = '0;
        else if (v[8]) begin
          expMem[r * COLS + c] = v;
          prot = v[2];
        end else if (prot || (v[9] && !strap)) expMem[r * COLS + c] = v;
        else expMem[r * COLS + c] = '0;
      end
    end
  endtask

  task automatic runOp(input bit erase, input bit strap, input bit disturb,
                       input bit lineCheck);
    int doneAt = -1;
    int doneCnt = 0;
    int fails = 0;
    buildExpected(erase, strap);
    @(negedge clk);
    loadReq = 1'b1; monClr = 1'b1;
    @(negedge clk);
    loadReq = 1'b0; monClr = 1'b0;
    eraseMode = erase; rulingErasable = strap; startReq = 1'b1;
    @(posedge clk);
    @(negedge clk);
    startReq = 1'b0;
    check(dmaActive && memRdEn && memCol == '0 && memRow == '0, "R1",
          {dmaActive, memRdEn, 8'(memCol)}, 10'h300);
    for (int n = 0; n <= 2 * CELLS + 4; n++) begin
      if (disturb && n == 777) begin
        startReq = 1'b1; eraseMode = ~erase; rulingErasable = ~strap;
      end
      if (disturb && n == 780) startReq = 1'b0;
      if (disturb && n == 2001) begin startReq = 1'b1; end
      if (disturb && n == 2002) startReq = 1'b0;
      if (scanDone) begin
        doneCnt++;
        if (doneAt < 0) begin
          doneAt = n;
          check(!dmaActive && memCol == '0 && memRow == '0, "R4",
                {dmaActive, 8'(memCol)}, 0);
        end
      end
      @(posedge clk);
      @(negedge clk);
    end
    startReq = 1'b0;
    check(doneAt == 2 * CELLS, disturb ? "R10" : "R4", doneAt, 2 * CELLS);
    check(doneCnt == 1, "R4", doneCnt, 1);
    check(orderErr == 0 && monIdx == CELLS, "R2 R3", orderErr, 0);
    for (int i = 0; i < CELLS; i++) begin
      string tag;
      if (!erase) tag = "R5";
      else if (img[i][8]) tag = "R6";
      else if (lineCheck && (i % COLS) < 2) tag = "R8";
      else if (img[i][9]) tag = "R9";
      else tag = "R7";
      if (disturb) tag = {tag, " R11"};
      checks++;
      if (mem[i] !== expMem[i]) begin
        errors++;
        fails++;
        if (fails <= 5)
          $display("FAIL %s cell %0d actual=%0h expected=%0h", tag, i, mem[i], expMem[i]);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd4021));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12: reset state
    check(!dmaActive && !scanDone && !memRdEn && !memWrEn, "R12",
          {dmaActive, scanDone, memRdEn, memWrEn}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!dmaActive && !memRdEn && !memWrEn, "R12", {dmaActive, memRdEn}, 0);

    // R5: page clear on random page
    for (int i = 0; i < CELLS; i++) img[i] = randCell();
    runOp(1'b0, 1'b0, 1'b0, 1'b0);

    // R6 R7 R9: erase with ruling preserved
    for (int i = 0; i < CELLS; i++) img[i] = randCell();
    runOp(1'b1, 1'b0, 1'b0, 1'b0);

    // R9: erase with ruling erasable
    for (int i = 0; i < CELLS; i++) img[i] = randCell();
    runOp(1'b1, 1'b1, 1'b0, 1'b0);

    // R8: protecting attribute codes at line ends, plain data after
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        logic [9:0] v = 10'(8'h41 + c % 26);
        if (c == 0 && r % 2 == 0) v = 10'h104;
        if (c == COLS - 1) v = 10'h104;
        img[r * COLS + c] = v;
      end
    runOp(1'b1, 1'b0, 1'b0, 1'b1);

    // R10 R11: start and config changes during a running erase
    for (int i = 0; i < CELLS; i++) img[i] = randCell();
    runOp(1'b1, 1'b0, 1'b1, 1'b0);

    // R7: dense attribute codes with both protection values
    for (int i = 0; i < CELLS; i++)
      img[i] = (i % 7 == 0) ? {1'b0, 1'b1, 8'(($urandom % 2) << 2)} : 10'($urandom % 256);
    runOp(1'b1, 1'b1, 1'b0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule